// File: doc/BRIEF.md
# Scatter/Gather Descriptor-Chain DMA Sequencer

This block is a single-channel DMA engine driven by a chain of descriptors in memory. Software builds the chain, writes the address of the first descriptor into the block, and sets a go bit. The engine reads each descriptor, loads that descriptor's control word into its active control register, and copies the data one transfer unit at a time. Each unit is one sized read followed by one sized write. The engine then either follows the descriptor's next pointer or stops. Interrupts are raised as each descriptor's enable bits ask, so a chain can interrupt only once, on its final element.

The engine shares one synchronous memory port for descriptor fetches and data movement. Read data returns one cycle after a read request, and there is no stall. Software controls the block through a small word-indexed register port. While the engine is halted or stopped, the same port shows the descriptor under way and the units still left in it, so software can compute the residue.

Top module: `sg_dma_seq`

## Requirements
- R1: After reset, every readable register (indexes 0 to 4) reads zero, all three interrupt outputs are low and `mem_req` is low.
- R2: Register indexes are 0 = go (bit 0), 1 = descriptor address, 2 = live count/control word, 3 = status, 4 = active control word. Setting go makes the engine fetch five 32-bit words at the descriptor address plus 0, 4, 8, 12 and 16, in this order: control, source, destination, count/control, next pointer. After the fetch, index 4 reads back that descriptor's control word.
- R3: Control bits [1:0] choose the unit size: 0 = 1 byte, 1 = 2, 2 = 4, 3 = 8. Count/control bits [15:0] give the number of units. Each unit is a read of `mem_size` = the size code at the source, then a write of the returned data to the destination in the next cycle. Both addresses then advance by the unit size. The memory port carries data right-justified in little-endian byte order.
- R4: Count/control bit 31 set makes the engine fetch the descriptor at the next pointer once the current one is done. When it is clear, the engine stops and the go bit reads 0.
- R5: Count/control bit 30 sets status bit 0 (`irq_tc`) when that descriptor completes. Bit 29 sets status bit 1 (`irq_eot`) when that descriptor ends the chain. Each takes effect only while control bit 2 (channel interrupt enable) of the same descriptor is set. Interrupts stay high until software clears them.
- R6: A source or destination address that is not a multiple of the unit size sets status bit 2, clears go and moves no data. If count/control bit 28 and control bit 2 are both set, it also sets status bit 3 (`irq_err`).
- R7: Clearing go stops the engine before its next unit. Index 1 then shows the descriptor being processed, index 2 bits [15:0] show the units not yet moved, and status bit 4 (busy) reads 0.
- R8: Writing 1 to a status bit clears it: bit 0, bit 1, bit 3, or bit 2, which clears bits 2 and 3 together. Writing 0 leaves the bit unchanged.
- R9: A write to index 1 while the engine is busy is ignored.
- R10: A descriptor with a count of zero moves no data. Its link and interrupt bits are still acted on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on `reg_addr`) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address |
| mem_size | output | 2 | Access size code (bytes = 1 << code) |
| mem_wdata | output | 64 | Write data, right-justified |
| mem_rdata | input | 64 | Read data, valid one cycle after a read request |
| irq_tc | output | 1 | Descriptor-completion interrupt (level) |
| irq_eot | output | 1 | Chain-end interrupt (level) |
| irq_err | output | 1 | Alignment-error interrupt (level) |

## Verification
The assertions watch properties that hold on every cycle:
- every data write directly follows a read;
- data writes are aligned to their size;
- the count drops by exactly one per write;
- an idle engine makes no memory requests;
- a completion interrupt holds until it is cleared;
- an error interrupt never appears with go still set.

Only the bench scenarios can show the rest:
- that bytes land at the right destinations;
- that chains follow or stop at the link bit;
- that interrupt qualification works per descriptor;
- that a halt leaves a residue consistent with the data actually moved;
- that a head-address write during a run is ignored.

// File: rtl/sgd_pkg.sv
package sgd_pkg;

    localparam int WORD_W     = 32;
    localparam int MEM_DW     = 64;
    localparam int RA_W       = 3;
    localparam int DESC_WORDS = 5;
    localparam int IDX_W      = $clog2(DESC_WORDS);

    // descriptor word slots
    localparam int W_CTRL = 0;
    localparam int W_SRC  = 1;
    localparam int W_DST  = 2;
    localparam int W_CC   = 3;
    localparam int W_NXT  = 4;

    // register indexes
    localparam logic [RA_W-1:0] RA_GO   = 3'd0;
    localparam logic [RA_W-1:0] RA_DESC = 3'd1;
    localparam logic [RA_W-1:0] RA_CNT  = 3'd2;
    localparam logic [RA_W-1:0] RA_STAT = 3'd3;
    localparam logic [RA_W-1:0] RA_CTRL = 3'd4;

    // bit positions
    localparam int CW_CIE   = 2;
    localparam int CC_LINK  = 31;
    localparam int CC_TCIE  = 30;
    localparam int CC_EOTIE = 29;
    localparam int CC_ERRIE = 28;
    localparam int ST_TC    = 0;
    localparam int ST_EOT   = 1;
    localparam int ST_ERR   = 2;
    localparam int ST_ERRQ  = 3;

    localparam logic [1:0] SZ_WORD = 2'd2;

    typedef enum logic [2:0] {
        S_IDLE, S_FREQ, S_FWAIT, S_CHECK, S_RD, S_WR, S_DONE
    } eng_state_e;

    // bit order matches status register bits 3..0
    typedef struct packed {
        logic err_irq;
        logic err;
        logic eot;
        logic tc;
    } evt_t;

    function automatic logic [3:0] unit_bytes(input logic [1:0] code);
        return 4'b0001 << code;
    endfunction

    function automatic logic [WORD_W-1:0] unit_mask(input logic [1:0] code);
        return (32'd1 << code) - 32'd1;
    endfunction

endpackage

// File: rtl/sgd_align_chk.sv
module sgd_align_chk
    import sgd_pkg::*;
(
    input  logic [1:0] wcode,
    input  logic [2:0] src_lo,
    input  logic [2:0] dst_lo,
    output logic       bad
);
    logic [2:0] mask;

    always_comb begin
        mask = unit_mask(wcode)[2:0];
        bad  = |(src_lo & mask) || |(dst_lo & mask);
    end
endmodule

// File: rtl/sgd_engine.sv
module sgd_engine
    import sgd_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              head_we,
    input  logic [WORD_W-1:0] head_data,
    output logic              mem_req,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [1:0]        mem_size,
    output logic [MEM_DW-1:0] mem_wdata,
    input  logic [MEM_DW-1:0] mem_rdata,
    output evt_t              evt,
    output logic              en_clr,
    output logic              busy,
    output logic [WORD_W-1:0] cur_desc,
    output logic [WORD_W-1:0] cc_live,
    output logic [WORD_W-1:0] ctrl_o
);
    localparam int HI_W = WORD_W - CNT_W;

    eng_state_e                         st_q;
    logic [IDX_W-1:0]                   idx_q;
    logic [DESC_WORDS-1:0][WORD_W-1:0]  fw_q;
    logic [WORD_W-1:0]                  desc_q, src_q, dst_q, nxt_q, ctrl_q;
    logic [CNT_W-1:0]                   cnt_q;
    logic [HI_W-1:0]                    cchi_q;
    logic                               misal;
    logic                               link, cie;
    logic [WORD_W-1:0]                  step;

    sgd_align_chk u_align (
        .wcode  (fw_q[W_CTRL][1:0]),
        .src_lo (fw_q[W_SRC][2:0]),
        .dst_lo (fw_q[W_DST][2:0]),
        .bad    (misal)
    );

    assign link     = cchi_q[CC_LINK - CNT_W];
    assign cie      = ctrl_q[CW_CIE];
    assign step     = WORD_W'(unit_bytes(ctrl_q[1:0]));
    assign busy     = (st_q != S_IDLE);
    assign cur_desc = desc_q;
    assign cc_live  = {cchi_q, cnt_q};
    assign ctrl_o   = ctrl_q;

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_size  = '0;
        mem_wdata = '0;
        case (st_q)
            S_FREQ: begin
                mem_req  = 1'b1;
                mem_addr = desc_q + (WORD_W'(idx_q) << 2);
                mem_size = SZ_WORD;
            end
            S_RD: begin
                mem_req  = en;
                mem_addr = src_q;
                mem_size = ctrl_q[1:0];
            end
            S_WR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = dst_q;
                mem_size  = ctrl_q[1:0];
                mem_wdata = mem_rdata;
            end
            default: ;
        endcase
    end

    always_comb begin
        evt.tc      = (st_q == S_DONE) && cie && cchi_q[CC_TCIE - CNT_W];
        evt.eot     = (st_q == S_DONE) && !link && cie && cchi_q[CC_EOTIE - CNT_W];
        evt.err     = (st_q == S_CHECK) && misal;
        evt.err_irq = (st_q == S_CHECK) && misal && fw_q[W_CTRL][CW_CIE]
                      && fw_q[W_CC][CC_ERRIE];
        en_clr      = ((st_q == S_DONE) && !link) || ((st_q == S_CHECK) && misal);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= S_IDLE;
            idx_q  <= '0;
            fw_q   <= '0;
            desc_q <= '0;
            src_q  <= '0;
            dst_q  <= '0;
            nxt_q  <= '0;
            ctrl_q <= '0;
            cnt_q  <= '0;
            cchi_q <= '0;
        end else begin
            case (st_q)
                S_IDLE: begin
                    if (head_we) desc_q <= head_data;
                    if (en) begin
                        idx_q <= '0;
                        st_q  <= S_FREQ;
                    end
                end
                S_FREQ: st_q <= S_FWAIT;
                S_FWAIT: begin
                    fw_q[idx_q] <= mem_rdata[WORD_W-1:0];
                    if (idx_q == IDX_W'(DESC_WORDS - 1)) begin
                        st_q <= S_CHECK;
                    end else begin
                        idx_q <= idx_q + IDX_W'(1);
                        st_q  <= S_FREQ;
                    end
                end
                S_CHECK: begin
                    ctrl_q <= fw_q[W_CTRL];
                    src_q  <= fw_q[W_SRC];
                    dst_q  <= fw_q[W_DST];
                    cnt_q  <= fw_q[W_CC][CNT_W-1:0];
                    cchi_q <= fw_q[W_CC][WORD_W-1:CNT_W];
                    nxt_q  <= fw_q[W_NXT];
                    if (misal)
                        st_q <= S_IDLE;
                    else if (fw_q[W_CC][CNT_W-1:0] == '0)
                        st_q <= S_DONE;
                    else
                        st_q <= S_RD;
                end
                S_RD: st_q <= en ? S_WR : S_IDLE;
                S_WR: begin
                    src_q <= src_q + step;
                    dst_q <= dst_q + step;
                    cnt_q <= cnt_q - CNT_W'(1);
                    st_q  <= (cnt_q == CNT_W'(1)) ? S_DONE : S_RD;
                end
                S_DONE: begin
                    if (link) begin
                        desc_q <= nxt_q;
                        idx_q  <= '0;
                        st_q   <= S_FREQ;
                    end else begin
                        st_q <= S_IDLE;
                    end
                end
                default: st_q <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sgd_regfile.sv
module sgd_regfile
    import sgd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [RA_W-1:0]   reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  evt_t              evt,
    input  logic              en_clr,
    input  logic              busy,
    input  logic [WORD_W-1:0] cur_desc,
    input  logic [WORD_W-1:0] cc_live,
    input  logic [WORD_W-1:0] ctrl,
    output logic              en,
    output logic              head_we,
    output logic [WORD_W-1:0] head_data,
    output logic              irq_tc,
    output logic              irq_eot,
    output logic              irq_err
);
    evt_t st_q;
    logic wr_go, wr_st;

    assign wr_go     = reg_we && (reg_addr == RA_GO);
    assign wr_st     = reg_we && (reg_addr == RA_STAT);
    assign head_we   = reg_we && (reg_addr == RA_DESC);
    assign head_data = reg_wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            en   <= 1'b0;
            st_q <= '0;
        end else begin
            if (wr_go)       en <= reg_wdata[0];
            else if (en_clr) en <= 1'b0;
            st_q.tc      <= evt.tc  | (st_q.tc  & ~(wr_st & reg_wdata[ST_TC]));
            st_q.eot     <= evt.eot | (st_q.eot & ~(wr_st & reg_wdata[ST_EOT]));
            st_q.err     <= evt.err | (st_q.err & ~(wr_st & reg_wdata[ST_ERR]));
            st_q.err_irq <= evt.err_irq |
                            (st_q.err_irq & ~(wr_st & (reg_wdata[ST_ERR] | reg_wdata[ST_ERRQ])));
        end
    end

    always_comb begin
        case (reg_addr)
            RA_GO:   reg_rdata = {31'b0, en};
            RA_DESC: reg_rdata = cur_desc;
            RA_CNT:  reg_rdata = cc_live;
            RA_STAT: reg_rdata = {27'b0, busy, st_q};
            RA_CTRL: reg_rdata = ctrl;
            default: reg_rdata = '0;
        endcase
    end

    assign irq_tc  = st_q.tc;
    assign irq_eot = st_q.eot;
    assign irq_err = st_q.err_irq;
endmodule

// File: rtl/sg_dma_seq.sv
module sg_dma_seq
    import sgd_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [RA_W-1:0]   reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [1:0]        mem_size,
    output logic [MEM_DW-1:0] mem_wdata,
    input  logic [MEM_DW-1:0] mem_rdata,
    output logic              irq_tc,
    output logic              irq_eot,
    output logic              irq_err
);
    evt_t              eng_evt;
    logic              chan_en, en_clr, eng_busy, head_we;
    logic [WORD_W-1:0] head_data, cur_desc, eng_cc, eng_ctrl;

    sgd_engine #(.CNT_W(CNT_W)) u_eng (
        .clk       (clk),
        .rst       (rst),
        .en        (chan_en),
        .head_we   (head_we),
        .head_data (head_data),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_size  (mem_size),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .evt       (eng_evt),
        .en_clr    (en_clr),
        .busy      (eng_busy),
        .cur_desc  (cur_desc),
        .cc_live   (eng_cc),
        .ctrl_o    (eng_ctrl)
    );

    sgd_regfile u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .evt       (eng_evt),
        .en_clr    (en_clr),
        .busy      (eng_busy),
        .cur_desc  (cur_desc),
        .cc_live   (eng_cc),
        .ctrl      (eng_ctrl),
        .en        (chan_en),
        .head_we   (head_we),
        .head_data (head_data),
        .irq_tc    (irq_tc),
        .irq_eot   (irq_eot),
        .irq_err   (irq_err)
    );
endmodule

// File: rtl/sgd_checker.sv
module sgd_checker
    import sgd_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              mem_req,
    input logic              mem_we,
    input logic [WORD_W-1:0] mem_addr,
    input logic [1:0]        mem_size,
    input logic              irq_tc,
    input logic              irq_err,
    input logic              reg_we,
    input logic [RA_W-1:0]   reg_addr,
    input logic              wdata_b0,
    input logic              busy,
    input logic              chan_en,
    input logic [CNT_W-1:0]  cnt
);
    AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> $past(mem_req && !mem_we)); // R3

    AST_WR_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> ((mem_addr & unit_mask(mem_size)) == '0)); // R6

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |=> (cnt == $past(cnt) - CNT_W'(1))); // R7

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req); // R4

    AST_TC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (irq_tc && !(reg_we && reg_addr == RA_STAT && wdata_b0)) |=> irq_tc); // R8

    AST_ERR_HALTS: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_err) |-> !chan_en); // R6
endmodule

bind sg_dma_seq sgd_checker #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_size (mem_size),
    .irq_tc   (irq_tc),
    .irq_err  (irq_err),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .wdata_b0 (reg_wdata[0]),
    .busy     (eng_busy),
    .chan_en  (chan_en),
    .cnt      (eng_cc[CNT_W-1:0])
);

// File: tb/test_sg_dma_seq.sv
`timescale 1ns/1ps
module test_sg_dma_seq;
    import sgd_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr;
    logic [1:0]  mem_size;
    logic [63:0] mem_wdata;
    logic [63:0] mem_rdata = '0;
    logic        irq_tc, irq_eot, irq_err;

    always #4 clk = ~clk;

    sg_dma_seq i_sg_dma_seq (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .irq_tc(irq_tc),
        .irq_eot(irq_eot), .irq_err(irq_err)
    );

    logic [7:0] mem    [0:4095];
    logic [7:0] shadow [0:4095];
    int unsigned n_vec = 0;
    int unsigned n_bad = 0;
    int unsigned cyc   = 0;

    // sized little-endian memory, one-cycle read latency
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) begin
                for (int b = 0; b < (1 << mem_size); b++)
                    mem[12'(mem_addr + 32'(b))] = mem_wdata[8*b +: 8];
            end else begin
                logic [63:0] rd;
                rd = '0;
                for (int b = 0; b < (1 << mem_size); b++)
                    rd[8*b +: 8] = mem[12'(mem_addr + 32'(b))];
                mem_rdata <= rd;
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles, expected fewer", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        #1 reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic put32(input int a, input logic [31:0] v);
        for (int b = 0; b < 4; b++) mem[12'(a + b)] = v[8*b +: 8];
    endtask

    function automatic logic [31:0] sh32(input logic [31:0] a);
        logic [31:0] v;
        for (int b = 0; b < 4; b++) v[8*b +: 8] = shadow[12'(a + 32'(b))];
        return v;
    endfunction

    task automatic put_desc(input int base, input logic [31:0] c, input logic [31:0] s,
                            input logic [31:0] d, input logic [31:0] cc, input logic [31:0] n);
        put32(base, c); put32(base + 4, s); put32(base + 8, d);
        put32(base + 12, cc); put32(base + 16, n);
    endtask

    function automatic logic [31:0] mk_cc(input bit link, input bit tcie, input bit eotie,
                                          input bit errie, input int cnt);
        return {link, tcie, eotie, errie, 12'h0, 16'(cnt)};
    endfunction

    // reference walk of the chain on the shadow image
    task automatic model_chain(input logic [31:0] head, output logic [3:0] est);
        logic [31:0] a, c, s, d, cc;
        logic [31:0] msk;
        logic [7:0]  tmp [0:7];
        bit          fin;
        int          nb;
        est = '0; a = head; fin = 0;
        for (int g = 0; g < 16 && !fin; g++) begin
            c = sh32(a); s = sh32(a + 4); d = sh32(a + 8); cc = sh32(a + 12);
            msk = (32'd1 << c[1:0]) - 1; nb = 1 << c[1:0];
            if (((s & msk) != 0) || ((d & msk) != 0)) begin
                est[2] = 1'b1;
                if (c[2] && cc[28]) est[3] = 1'b1;
                fin = 1;
            end else begin
                for (int u = 0; u < int'(cc[15:0]); u++) begin
                    for (int b = 0; b < nb; b++) tmp[b] = shadow[12'(s + 32'(b))];
                    for (int b = 0; b < nb; b++) shadow[12'(d + 32'(b))] = tmp[b];
                    s += 32'(nb); d += 32'(nb);
                end
                if (c[2] && cc[30]) est[0] = 1'b1;
                if (cc[31]) a = sh32(a + 16);
                else begin
                    if (c[2] && cc[29]) est[1] = 1'b1;
                    fin = 1;
                end
            end
        end
    endtask

    task automatic wait_idle(input string req);
        logic [31:0] g, s;
        for (int k = 0; k < 4000; k++) begin
            reg_read(RA_GO, g); reg_read(RA_STAT, s);
            if (g[0] == 1'b0 && s[4] == 1'b0) return;
        end
        n_vec++; n_bad++;
        $display("FAIL %s: engine busy, actual busy expected idle", req);
    endtask

    task automatic run_chain(input logic [31:0] head, input string req);
        logic [3:0]  est;
        logic [31:0] v;
        int          diffs;
        reg_write(RA_STAT, 32'hF);
        for (int i = 0; i < 4096; i++) shadow[i] = mem[i];
        model_chain(head, est);
        reg_write(RA_DESC, head);
        reg_write(RA_GO, 32'h1);
        wait_idle(req);
        diffs = 0;
        for (int i = 0; i < 4096; i++) if (mem[i] !== shadow[i]) diffs++;
        check({req, " memory image"}, 32'(diffs), 32'd0);
        reg_read(RA_STAT, v);
        check({req, " status"}, {28'd0, v[3:0]}, {28'd0, est});
        check({req, " irq pins"}, {29'd0, irq_err, irq_eot, irq_tc}, {29'd0, est[3], est[1], est[0]});
    endtask

    initial begin
        logic [31:0] v, r;
        int          done, bad;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        for (int a = 0; a < 5; a++) begin
            reg_read(3'(a), v);
            check("R1 register after reset", v, 32'd0);
        end
        check("R1 outputs after reset", {28'd0, mem_req, irq_err, irq_eot, irq_tc}, 32'd0);

        // R2 R3 R5: single word-wide descriptor
        for (int i = 0; i < 4096; i++) mem[i] = 8'($urandom);
        put_desc(0, 32'h0000_A006, 32'h100, 32'h800, mk_cc(0, 1, 1, 1, 4), 32'h0);
        run_chain(0, "R2 R3 R5 single");
        reg_read(RA_CTRL, v);
        check("R2 control reload", v, 32'h0000_A006);
        reg_read(RA_CNT, v);
        check("R3 count exhausted", {16'd0, v[15:0]}, 32'd0);

        // R8 write-one-to-clear
        reg_write(RA_STAT, 32'h1);
        reg_read(RA_STAT, v);
        check("R8 clear bit0 only", {28'd0, v[3:0]}, 32'h2);
        check("R8 irq pins", {30'd0, irq_eot, irq_tc}, 32'h2);
        reg_write(RA_STAT, 32'h0);
        reg_read(RA_STAT, v);
        check("R8 zero write no effect", {28'd0, v[3:0]}, 32'h2);

        // R4 R5: two linked descriptors, tc only on first, byte and dword units
        for (int i = 0; i < 4096; i++) mem[i] = 8'($urandom);
        put_desc(0,  32'h4, 32'h100, 32'h800, mk_cc(1, 1, 0, 1, 5), 32'h40);
        put_desc(64, 32'h7, 32'h200, 32'h900, mk_cc(0, 0, 0, 1, 3), 32'h0);
        run_chain(0, "R4 R5 two-link");

        // R5 channel interrupt enable clear
        for (int i = 0; i < 4096; i++) mem[i] = 8'($urandom);
        put_desc(0, 32'h1, 32'h102, 32'h806, mk_cc(0, 1, 1, 1, 6), 32'h0);
        run_chain(0, "R5 gated off");

        // R6 misaligned destination
        for (int i = 0; i < 4096; i++) mem[i] = 8'($urandom);
        put_desc(32, 32'h5, 32'h100, 32'h803, mk_cc(0, 1, 1, 1, 9), 32'h0);
        run_chain(32, "R6 misaligned");
        reg_read(RA_CNT, v);
        check("R6 count kept", {16'd0, v[15:0]}, 32'd9);
        reg_read(RA_DESC, v);
        check("R6 descriptor shown", v, 32'd32);
        reg_write(RA_STAT, 32'h4);
        reg_read(RA_STAT, v);
        check("R8 bit2 clears both error bits", {28'd0, v[3:0]}, 32'h0);

        // R10 zero-count descriptor linking onward
        for (int i = 0; i < 4096; i++) mem[i] = 8'($urandom);
        put_desc(0,  32'h5, 32'h100, 32'h800, mk_cc(1, 1, 0, 1, 0), 32'h20);
        put_desc(32, 32'h6, 32'h300, 32'hA00, mk_cc(0, 0, 1, 1, 2), 32'h0);
        run_chain(0, "R10 zero count");

        // R4 link clear stops early
        for (int i = 0; i < 4096; i++) mem[i] = 8'($urandom);
        put_desc(0,  32'h4, 32'h100, 32'h800, mk_cc(0, 0, 1, 1, 2), 32'h20);
        put_desc(32, 32'h4, 32'h300, 32'hA00, mk_cc(0, 1, 1, 1, 2), 32'h0);
        run_chain(0, "R4 link clear");

        // R7 R9 halt mid-descriptor
        for (int i = 0; i < 200; i++) begin
            mem[12'(256 + i)]  = 8'(i);
            mem[12'(2048 + i)] = 8'hEE;
        end
        mem[12'(2048 + 200)] = 8'hEE;
        put_desc(0, 32'h0, 32'h100, 32'h800, mk_cc(0, 1, 1, 1, 200), 32'h0);
        reg_write(RA_STAT, 32'hF);
        reg_write(RA_DESC, 32'h0);
        reg_write(RA_GO, 32'h1);
        repeat (20) @(negedge clk);
        reg_write(RA_DESC, 32'h40);
        repeat (20) @(negedge clk);
        reg_write(RA_GO, 32'h0);
        repeat (6) @(negedge clk);
        reg_read(RA_STAT, v);
        check("R7 halted not busy", {31'd0, v[4]}, 32'd0);
        check("R7 no completion irq", {31'd0, irq_tc}, 32'd0);
        reg_read(RA_DESC, v);
        check("R9 busy head write ignored", v, 32'd0);
        reg_read(RA_CNT, r);
        check("R7 residue in range", {31'd0, (r[15:0] > 0 && r[15:0] < 200)}, 32'd1);
        done = 200 - int'(r[15:0]);
        bad = 0;
        for (int i = 0; i < done; i++) if (mem[12'(2048 + i)] !== 8'(i)) bad++;
        if (mem[12'(2048 + done)] !== 8'hEE) bad++;
        check("R7 residue matches moved data", 32'(bad), 32'd0);

        // random chains
        for (int t = 0; t < 24; t++) begin
            int nd;
            for (int i = 0; i < 4096; i++) mem[i] = 8'($urandom);
            nd = 1 + int'($urandom % 3);
            for (int i = 0; i < nd; i++) begin
                logic [1:0]  w;
                logic [31:0] s, d, c;
                int          cnt;
                w   = 2'($urandom);
                cnt = ($urandom % 8 == 0) ? 0 : 1 + int'($urandom % 8);
                s   = 32'(256 + i * 384) + ((32'($urandom % 8)) << w);
                d   = 32'(2048 + i * 384) + ((32'($urandom % 8)) << w);
                if (w != 0 && $urandom % 8 == 0) s = s + 1;
                c   = {29'($urandom), 1'($urandom), w};
                put_desc(i * 32, c, s, d,
                         mk_cc(i < nd - 1, 1'($urandom), i == nd - 1, 1'($urandom), cnt),
                         32'((i + 1) * 32));
            end
            run_chain(0, "R3 R4 R5 R6 random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule